// File: doc/BRIEF.md
# Linked-List Command Fetch Walker

This block follows a chain of command nodes held in main memory and passes the payload of each node, word by word, to a downstream command consumer. A node begins with one header word: its top byte is the number of payload words that follow it, and its low 24 bits point to the next node. The walker issues one memory read at a time: first the header, then each payload word. It holds every payload word until the consumer accepts it, so the consumer can slow the walk down but cannot drop a word.

While it walks, the walker builds a bus-cost estimate for the list. The walk stops when the address it is about to visit has bit 23 set. It also stops after a parameterised number of nodes, on the assumption that the list loops back on itself; that stop raises an error flag. A single-step option, chosen at start, visits exactly one node and reports where the chain continues. The commands themselves are not interpreted.

When it finishes, the walker raises a one-cycle completion pulse. The cost, the stop address and the error flag stay valid on their outputs until the next start.

Top module: `list_dma_walker`

## Requirements
- R1: A start whose address has bit 23 set finishes at once: no memory read, no consumer word, cost 0, `stop_addr` equal to the start address.
- R2: Header bits [31:24] are the payload length and bits [23:0] are the next-node address. The walk follows the next-node addresses until it reaches an address with bit 23 set, and `stop_addr` then holds that address.
- R3: The payload words of a node are the `len` words that directly follow its header, read and forwarded in ascending address order. A node with length zero forwards nothing and costs one read.
- R4: Every memory read uses byte address bits [20:0] with bits [1:0] forced to zero, so address bits 22:21 and 1:0 of a node pointer are ignored. Payload addresses wrap from 0x1FFFFC to 0x000000.
- R5: The cost adds NODE_COST (10) for every visited node, plus PAY_COST (5) plus `len` for each node whose length is nonzero.
- R6: While `snk_valid` is high and `snk_ready` is low, `snk_valid` stays high and `snk_data` stays stable. No word is lost or duplicated under backpressure, and no read is outstanding while a word waits.
- R7: If LOOP_LIMIT nodes have been visited and the next address does not have bit 23 set, the walk aborts. `loop_err` is then 1 and `stop_addr` holds the unvisited address. A list of exactly LOOP_LIMIT nodes that ends properly raises no error.
- R8: With `step_mode` high at start, the walk stops after one node (or at once on an end address). `stop_addr` then holds that node's next-node field and `loop_err` is 0.
- R9: `done` is high for exactly one cycle per walk and `busy` is low in the cycle that follows. `cost`, `stop_addr` and `loop_err` are valid with `done` and hold until the next accepted start. A start while busy is ignored.
- R10: While `rd_req_valid` is high and `rd_req_ready` is low, the request stays asserted with a stable address.
- R11: After reset the walker is idle: `busy`, `done`, `loop_err`, `rd_req_valid` and `snk_valid` are 0, and `cost` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a walk (sampled while idle) |
| start_addr | input | 24 | Address of the first node |
| step_mode | input | 1 | Visit one node only (sampled with start) |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle completion pulse |
| loop_err | output | 1 | Walk aborted at the node limit |
| cost | output | COST_W | Accumulated bus-cost estimate |
| stop_addr | output | 24 | Address at which the walk stopped |
| rd_req_valid | output | 1 | Memory read request |
| rd_req_ready | input | 1 | Memory accepts the request |
| rd_req_addr | output | MEM_AW | Word-aligned byte address of the read |
| rd_rsp_valid | input | 1 | Read data returned |
| rd_rsp_data | input | 32 | Read data |
| snk_valid | output | 1 | Payload word available to the consumer |
| snk_ready | input | 1 | Consumer accepts the word |
| snk_data | output | 32 | Payload word |

## Verification
A corrupted remaining-word count or read pointer shows up at the consumer port within one node. The bench compares every forwarded word against its own walk of the memory image, so it sees a missing, extra or shifted word there, or an address that fails to wrap in the read log. A wrong node counter or cost adder is visible only at completion. It appears as a wrong cost, a wrong stop address or an early or missing `loop_err` on the `done` cycle, so the limit is tested at exactly LOOP_LIMIT and at one node more. Handshake slips show up at once as an unstable word or address under the randomised stall patterns.

// File: rtl/lwalk_pkg.sv
// Shared types for the linked-list walker.
// Assumes a 32-bit header: length in the top byte, link in the low 24 bits.
package lwalk_pkg;
    localparam int WORD_W = 32;
    localparam int LEN_W  = 8;
    localparam int LINK_W = 24;

    typedef enum logic [2:0] {
        W_IDLE, W_NODE, W_HDR_REQ, W_HDR_WAIT,
        W_PAY_REQ, W_PAY_WAIT, W_PAY_SEND, W_DONE
    } walk_state_t;

    typedef struct packed {
        logic [LEN_W-1:0]  len;
        logic [LINK_W-1:0] link;
    } node_hdr_t;
endpackage

// File: rtl/lwalk_hdr_decode.sv
// Splits a header word into length and link and computes the node's cost.
// Purely combinational; assumes the word is a valid header when used.
module lwalk_hdr_decode
    import lwalk_pkg::*;
#(
    parameter int COST_W    = 32,
    parameter int NODE_COST = 10,
    parameter int PAY_COST  = 5
) (
    input  logic [WORD_W-1:0] word,
    output logic [LEN_W-1:0]  len,
    output logic [LINK_W-1:0] link,
    output logic              len_zero,
    output logic [COST_W-1:0] cost_inc
);
    node_hdr_t hdr;

    // Field split and cost of one node
    always_comb begin
        hdr      = node_hdr_t'(word);
        len      = hdr.len;
        link     = hdr.link;
        len_zero = (hdr.len == '0);
        cost_inc = COST_W'(NODE_COST);
        if (!len_zero)
            cost_inc = cost_inc + COST_W'(PAY_COST) + COST_W'(hdr.len);
    end
endmodule

// File: rtl/lwalk_cost_acc.sv
// Accumulates the walk cost and counts visited nodes against the loop limit.
// Assumes clear and add never coincide.
module lwalk_cost_acc #(
    parameter int COST_W     = 32,
    parameter int LOOP_LIMIT = 8192,
    localparam int CNT_W     = $clog2(LOOP_LIMIT + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              add,
    input  logic [COST_W-1:0] inc,
    output logic [COST_W-1:0] total,
    output logic              any_node,
    output logic              at_limit
);
    logic [CNT_W-1:0] node_cnt;

    // Cost sum and node count registers
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            total    <= '0;
            node_cnt <= '0;
        end else if (add) begin
            total    <= total + inc;
            node_cnt <= node_cnt + 1'b1;
        end
    end

    // Limit and first-node flags
    always_comb begin
        any_node = (node_cnt != '0);
        at_limit = (node_cnt == CNT_W'(LOOP_LIMIT));
    end
endmodule

// File: rtl/lwalk_word_hold.sv
// One-word holding stage between the memory response and the consumer.
// Assumes load only arrives while empty.
module lwalk_word_hold #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    input  logic              out_ready,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data
);
    // Capture a word and keep it until the consumer takes it
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else if (load) begin
            out_valid <= 1'b1;
            out_data  <= load_data;
        end else if (out_valid && out_ready) begin
            out_valid <= 1'b0;
        end
    end
endmodule

// File: rtl/list_dma_walker.sv
// Walks a linked list of command nodes and streams their payloads.
// Assumes one outstanding read at a time and a memory response that
// arrives at least one cycle after the request is accepted.
module list_dma_walker
    import lwalk_pkg::*;
#(
    parameter int MEM_AW     = 21,
    parameter int COST_W     = 32,
    parameter int LOOP_LIMIT = 8192,
    parameter int NODE_COST  = 10,
    parameter int PAY_COST   = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [23:0]       start_addr,
    input  logic              step_mode,
    output logic              busy,
    output logic              done,
    output logic              loop_err,
    output logic [COST_W-1:0] cost,
    output logic [23:0]       stop_addr,
    output logic              rd_req_valid,
    input  logic              rd_req_ready,
    output logic [MEM_AW-1:0] rd_req_addr,
    input  logic              rd_rsp_valid,
    input  logic [31:0]       rd_rsp_data,
    output logic              snk_valid,
    input  logic              snk_ready,
    output logic [31:0]       snk_data
);
    localparam logic [MEM_AW-1:0] WORD_STEP = MEM_AW'(4);
    localparam int END_BIT = LINK_W - 1;

    walk_state_t       state;
    logic [LINK_W-1:0] cur_addr;
    logic [MEM_AW-1:0] rd_ptr;
    logic [LEN_W-1:0]  remaining;
    logic              step_q;

    logic [LEN_W-1:0]  hdr_len;
    logic [LINK_W-1:0] hdr_link;
    logic              hdr_len_zero;
    logic [COST_W-1:0] hdr_cost;
    logic              acc_clear, acc_add, any_node, at_limit;
    logic              hold_load;

    lwalk_hdr_decode #(
        .COST_W(COST_W), .NODE_COST(NODE_COST), .PAY_COST(PAY_COST)
    ) u_dec (
        .word(rd_rsp_data), .len(hdr_len), .link(hdr_link),
        .len_zero(hdr_len_zero), .cost_inc(hdr_cost)
    );

    lwalk_cost_acc #(
        .COST_W(COST_W), .LOOP_LIMIT(LOOP_LIMIT)
    ) u_acc (
        .clk(clk), .rst_n(rst_n), .clear(acc_clear), .add(acc_add),
        .inc(hdr_cost), .total(cost), .any_node(any_node), .at_limit(at_limit)
    );

    lwalk_word_hold #(
        .DATA_W(WORD_W)
    ) u_hold (
        .clk(clk), .rst_n(rst_n), .load(hold_load), .load_data(rd_rsp_data),
        .out_ready(snk_ready), .out_valid(snk_valid), .out_data(snk_data)
    );

    // Strobes into the helpers and port views of the state
    always_comb begin
        acc_clear    = (state == W_IDLE) && start;
        acc_add      = (state == W_HDR_WAIT) && rd_rsp_valid;
        hold_load    = (state == W_PAY_WAIT) && rd_rsp_valid;
        rd_req_valid = (state == W_HDR_REQ) || (state == W_PAY_REQ);
        rd_req_addr  = rd_ptr;
        busy         = (state != W_IDLE);
        done         = (state == W_DONE);
    end

    // Walk sequencer: node checks, header fetch, payload fetch and forward
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= W_IDLE;
            cur_addr  <= '0;
            rd_ptr    <= '0;
            remaining <= '0;
            step_q    <= 1'b0;
            loop_err  <= 1'b0;
            stop_addr <= '0;
        end else begin
            case (state)
                W_IDLE: if (start) begin
                    cur_addr <= start_addr;
                    step_q   <= step_mode;
                    loop_err <= 1'b0;
                    state    <= W_NODE;
                end
                W_NODE: begin
                    if (cur_addr[END_BIT] || (step_q && any_node)) begin
                        stop_addr <= cur_addr;
                        state     <= W_DONE;
                    end else if (at_limit) begin
                        stop_addr <= cur_addr;
                        loop_err  <= 1'b1;
                        state     <= W_DONE;
                    end else begin
                        rd_ptr <= {cur_addr[MEM_AW-1:2], 2'b00};
                        state  <= W_HDR_REQ;
                    end
                end
                W_HDR_REQ: if (rd_req_ready) state <= W_HDR_WAIT;
                W_HDR_WAIT: if (rd_rsp_valid) begin
                    cur_addr  <= hdr_link;
                    remaining <= hdr_len;
                    rd_ptr    <= rd_ptr + WORD_STEP;
                    state     <= hdr_len_zero ? W_NODE : W_PAY_REQ;
                end
                W_PAY_REQ: if (rd_req_ready) state <= W_PAY_WAIT;
                W_PAY_WAIT: if (rd_rsp_valid) begin
                    rd_ptr <= rd_ptr + WORD_STEP;
                    state  <= W_PAY_SEND;
                end
                W_PAY_SEND: if (snk_valid && snk_ready) begin
                    remaining <= remaining - 1'b1;
                    state     <= (remaining == LEN_W'(1)) ? W_NODE : W_PAY_REQ;
                end
                W_DONE: state <= W_IDLE;
                default: state <= W_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/lwalk_checker.sv
// Protocol and completion properties of the walker, bound to its top.
module lwalk_checker #(
    parameter int MEM_AW = 21
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              done,
    input logic              loop_err,
    input logic              rd_req_valid,
    input logic              rd_req_ready,
    input logic [MEM_AW-1:0] rd_req_addr,
    input logic              snk_valid,
    input logic              snk_ready,
    input logic [31:0]       snk_data
);
    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_sink_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (snk_valid && !snk_ready) |=> (snk_valid && $stable(snk_data)));

    assert_single_phase_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_req_valid && snk_valid));

    assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req_valid && !rd_req_ready) |=> (rd_req_valid && $stable(rd_req_addr)));

    assert_req_align_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_valid |-> (rd_req_addr[1:0] == 2'b00));

    assert_err_with_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(loop_err) |-> done);

    assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!rd_req_valid && !snk_valid));
endmodule

bind list_dma_walker lwalk_checker #(.MEM_AW(MEM_AW)) u_lwalk_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .loop_err(loop_err),
    .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready),
    .rd_req_addr(rd_req_addr), .snk_valid(snk_valid), .snk_ready(snk_ready),
    .snk_data(snk_data)
);

// File: tb/list_dma_walker_test.sv
`timescale 1ns/1ps
module list_dma_walker_test;
    localparam int LIMIT  = 16;
    localparam int COST_W = 32;
    localparam int LOGN   = 4096;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [23:0]       start_addr = '0;
    logic              step_mode = 1'b0;
    logic              busy, done, loop_err;
    logic [COST_W-1:0] cost;
    logic [23:0]       stop_addr;
    logic              rd_req_valid, rd_req_ready;
    logic [20:0]       rd_req_addr;
    logic              rd_rsp_valid;
    logic [31:0]       rd_rsp_data;
    logic              snk_valid, snk_ready;
    logic [31:0]       snk_data;

    list_dma_walker #(.LOOP_LIMIT(LIMIT), .COST_W(COST_W)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
        .step_mode(step_mode), .busy(busy), .done(done), .loop_err(loop_err),
        .cost(cost), .stop_addr(stop_addr), .rd_req_valid(rd_req_valid),
        .rd_req_ready(rd_req_ready), .rd_req_addr(rd_req_addr),
        .rd_rsp_valid(rd_rsp_valid), .rd_rsp_data(rd_rsp_data),
        .snk_valid(snk_valid), .snk_ready(snk_ready), .snk_data(snk_data)
    );

    // Memory image, indexed by byte address bits [11:2]
    logic [31:0] mem [0:1023];
    logic [15:0] lfsr = 16'hACE1;
    logic        stall = 1'b0;
    int tests = 0, fails = 0;
    int rd_n = 0, cap_n = 0, done_n = 0;
    logic [20:0] rd_log [0:LOGN-1];
    logic [31:0] cap [0:LOGN-1];

    always @(negedge clk) lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    assign rd_req_ready = stall ? lfsr[0] : 1'b1;
    assign snk_ready    = stall ? lfsr[2] : 1'b1;

    // One-cycle-latency memory and port monitors
    always @(posedge clk) begin
        if (!rst_n) begin
            rd_rsp_valid <= 1'b0;
            rd_rsp_data  <= '0;
        end else begin
            rd_rsp_valid <= rd_req_valid && rd_req_ready;
            rd_rsp_data  <= mem[rd_req_addr[11:2]];
            if (rd_req_valid && rd_req_ready) begin
                rd_log[rd_n % LOGN] <= rd_req_addr;
                rd_n <= rd_n + 1;
            end
            if (snk_valid && snk_ready) begin
                cap[cap_n % LOGN] <= snk_data;
                cap_n <= cap_n + 1;
            end
            if (done) done_n <= done_n + 1;
        end
    end

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic int idx(input logic [23:0] a);
        return int'(a[11:2]);
    endfunction

    task automatic clear_mem();
        for (int i = 0; i < 1024; i++) mem[i] = 32'h0;
    endtask

    task automatic put(input logic [23:0] a, input logic [31:0] w);
        mem[idx(a)] = w;
    endtask

    // Expected results from the requirements
    logic [31:0] exp_w [0:1023];
    int exp_n, exp_reads;
    longint exp_cost;
    logic [23:0] exp_stop;
    logic exp_err;

    task automatic model(input logic [23:0] sa, input logic step);
        logic [23:0] a;
        logic [31:0] h;
        logic [18:0] wa;
        int nodes, len;
        a = sa; nodes = 0; exp_n = 0; exp_cost = 0; exp_err = 0; exp_reads = 0;
        forever begin
            if (a[23]) break;
            if (step && nodes != 0) break;
            if (nodes == LIMIT) begin exp_err = 1; break; end
            h = mem[idx(a)];
            len = int'(h[31:24]);
            exp_cost += 10 + ((len != 0) ? 5 + len : 0);
            exp_reads += 1 + len;
            for (int i = 1; i <= len; i++) begin
                wa = a[20:2] + 19'(i);
                exp_w[exp_n] = mem[idx({3'b000, wa, 2'b00})];
                exp_n++;
            end
            nodes++;
            a = h[23:0];
        end
        exp_stop = a;
    endtask

    task automatic run_walk(input string req, input logic [23:0] sa, input logic step,
                            input logic st, input logic poke);
        int rb, cb, db, cyc;
        logic [COST_W-1:0] c_at_done;
        model(sa, step);
        rb = rd_n; cb = cap_n; db = done_n;
        @(negedge clk);
        stall = st; start = 1'b1; start_addr = sa; step_mode = step;
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            repeat (3) @(negedge clk);
            start = 1'b1; start_addr = 24'h000100; step_mode = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        cyc = 0;
        while (!done && cyc < 20000) begin @(negedge clk); cyc++; end
        chk(req, "R9 done reached", longint'(cyc < 20000), 1);
        chk(req, "R5 cost", longint'(cost), exp_cost);
        chk(req, "R2 stop address", longint'(stop_addr), longint'(exp_stop));
        chk(req, "R7 loop error", longint'(loop_err), longint'(exp_err));
        c_at_done = cost;
        @(negedge clk);
        chk(req, "R9 done low after pulse", longint'(done), 0);
        chk(req, "R9 busy low after done", longint'(busy), 0);
        chk(req, "R9 single done pulse", longint'(done_n - db), 1);
        chk(req, "R9 cost held", longint'(cost), longint'(c_at_done));
        chk(req, "R3 word count", longint'(cap_n - cb), longint'(exp_n));
        for (int i = 0; i < exp_n && i < cap_n - cb; i++)
            chk(req, "R3/R6 payload word", longint'(cap[(cb + i) % LOGN]), longint'(exp_w[i]));
        chk(req, "R3 read count", longint'(rd_n - rb), longint'(exp_reads));
        stall = 1'b0;
    endtask

    logic finished = 1'b0;
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++; tests++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int rb;
        clear_mem();
        repeat (4) @(negedge clk);
        // R11: reset state
        chk("R11", "busy", longint'(busy), 0);
        chk("R11", "done", longint'(done), 0);
        chk("R11", "loop_err", longint'(loop_err), 0);
        chk("R11", "cost", longint'(cost), 0);
        chk("R11", "rd_req_valid", longint'(rd_req_valid), 0);
        chk("R11", "snk_valid", longint'(snk_valid), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1: end marker at start
        run_walk("R1", 24'h800000, 1'b0, 1'b0, 1'b0);
        run_walk("R1", 24'hFFFFFF, 1'b0, 1'b0, 1'b0);

        // R2/R3/R5: three-node chain with lengths 2, 0, 5
        put(24'h000100, {8'd2, 24'h000200});
        put(24'h000104, 32'hA0000001); put(24'h000108, 32'hA0000002);
        put(24'h000200, {8'd0, 24'h000300});
        put(24'h000300, {8'd5, 24'hC01234});
        for (int i = 1; i <= 5; i++) put(24'h000300 + 24'(4 * i), 32'hB0000000 + i);
        run_walk("R2", 24'h000100, 1'b0, 1'b0, 1'b0);
        chk("R5", "three-node cost", longint'(cost), 47);
        run_walk("R6", 24'h000100, 1'b0, 1'b1, 1'b0);
        // R9: start while busy ignored
        run_walk("R9", 24'h000100, 1'b0, 1'b1, 1'b1);

        // R8: single step
        run_walk("R8", 24'h000100, 1'b1, 1'b0, 1'b0);
        chk("R8", "step stop address", longint'(stop_addr), 24'h000200);
        run_walk("R8", 24'h000200, 1'b1, 1'b1, 1'b0);
        run_walk("R8", 24'h8ABCDE, 1'b1, 1'b0, 1'b0);

        // R4: pointer bits 22:21 and 1:0 ignored
        put(24'h000400, {8'd1, 24'h600202});
        put(24'h000404, 32'hC0FFEE00);
        rb = rd_n;
        run_walk("R4", 24'h000400, 1'b0, 1'b0, 1'b0);
        chk("R4", "aliased header address", longint'(rd_log[(rb + 2) % LOGN]), 21'h000200);

        // R4: payload wrap at 2 MB
        clear_mem();
        put(24'h1FFFF8, {8'd3, 24'h800000});
        put(24'h1FFFFC, 32'h11111111); put(24'h000000, 32'h22222222);
        put(24'h000004, 32'h33333333);
        rb = rd_n;
        run_walk("R4", 24'h1FFFF8, 1'b0, 1'b1, 1'b0);
        chk("R4", "wrap read 0", longint'(rd_log[(rb + 0) % LOGN]), 21'h1FFFF8);
        chk("R4", "wrap read 1", longint'(rd_log[(rb + 1) % LOGN]), 21'h1FFFFC);
        chk("R4", "wrap read 2", longint'(rd_log[(rb + 2) % LOGN]), 21'h000000);
        chk("R4", "wrap read 3", longint'(rd_log[(rb + 3) % LOGN]), 21'h000004);

        // R3/R5: sweep of single-node lengths, alternating stalls
        for (int l = 0; l <= 20; l++) begin
            clear_mem();
            put(24'h000040, {8'(l), 24'h800000});
            for (int i = 1; i <= l; i++) put(24'h000040 + 24'(4 * i), 32'(l * 256 + i));
            run_walk("R3", 24'h000040, 1'b0, 1'(l % 2), 1'b0);
        end
        clear_mem();
        put(24'h000000, {8'd255, 24'h800000});
        for (int i = 1; i <= 255; i++) put(24'(4 * i), 32'hD000_0000 + i);
        run_walk("R5", 24'h000000, 1'b0, 1'b1, 1'b0);
        chk("R5", "max length cost", longint'(cost), 270);

        // R7: self loops
        clear_mem();
        put(24'h000080, {8'd1, 24'h000080});
        put(24'h000084, 32'h5A5A5A5A);
        run_walk("R7", 24'h000080, 1'b0, 1'b0, 1'b0);
        chk("R7", "self loop error", longint'(loop_err), 1);
        chk("R7", "self loop cost", longint'(cost), 256);
        put(24'h000080, {8'd0, 24'h000080});
        run_walk("R7", 24'h000080, 1'b0, 1'b1, 1'b0);

        // R7: chains of exactly LIMIT and LIMIT+1 nodes
        for (int n = LIMIT; n <= LIMIT + 1; n++) begin
            clear_mem();
            for (int k = 0; k < n; k++) begin
                put(24'h000100 + 24'(8 * k),
                    {8'd1, (k < n - 1) ? 24'h000100 + 24'(8 * (k + 1)) : 24'h800000});
                put(24'h000104 + 24'(8 * k), 32'(k + 7));
            end
            run_walk("R7", 24'h000100, 1'b0, 1'b0, 1'b0);
            chk("R7", "limit boundary error", longint'(loop_err), longint'(n > LIMIT));
        end

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule